// File: doc/BRIEF.md
# Two-Port Pin Expander Register Bank

This block is the register file of a 16-pin, two-port general purpose I/O expander. A serial bus engine (outside this block) first hands over a command byte that loads an internal pointer. It then issues byte writes or byte reads at that pointer. Each pair of adjacent codes maps one register to port 0 (pins 7..0) and port 1 (pins 15..8). After every byte access the pointer flips its lowest bit, so a controller can move through both halves of a pair without sending a new command.

The bank holds the settings for:
- pin direction, output value and input polarity;
- two-bit-per-pin drive strength;
- input latching, pull enable and pull direction;
- the interrupt mask;
- a port-wise open-drain switch.

The bank resamples the pins on every clock and presents them through the input-port codes. It drives per-pin output-enable and output-value lines toward the pads. It passes the latch and mask settings to a separate interrupt detector, and it reads back that detector's status, gated by the mask.

Top module: `gpx_regbank`

## Requirements
- R1: After reset the output-port and direction codes (02h/03h, 06h/07h) read FFh, polarity codes (04h/05h) read 00h, drive codes (40h–43h) read FFh, latch (44h/45h) and pull-enable (46h/47h) read 00h, pull-select (48h/49h) and mask (4Ah/4Bh) read FFh, and the open-drain code 4Fh reads 00h.
- R2: A command loads the pointer. Each accepted byte write or read then inverts pointer bit 0. Read data appears on `rd_data` with `rd_valid` one cycle after `rd_en`. A command beats a write, and a write beats a read in the same cycle; the losing read gets no `rd_valid`.
- R3: Codes 00h/01h return the pin values sampled one clock earlier, XOR the polarity bits of the same port.
- R4: A direction bit of 1 makes the pin an input with `pin_oe` low. A bit of 0 with push-pull selected drives `pin_out` to the output-port bit with `pin_oe` high.
- R5: With code 4Fh bit 0 (port 0) or bit 1 (port 1) set to 1, an output pin of that port only pulls low. `pin_oe` is high only while its output bit is 0, and `pin_out` is 0.
- R6: Code 4Fh stores only bits 1..0. Bits 7..2 always read 0.
- R7: Writes to codes 00h, 01h, 4Ch, 4Dh and to unmapped codes change nothing. Reads of unmapped codes return 00h.
- R8: Codes 4Ch/4Dh read the external status AND NOT mask, so a masked pin reads 0.
- R9: The `drive_str`, `latch_en`, `pull_en`, `pull_sel` and `irq_mask` outputs equal the stored registers. In `drive_str`, code 40h+k occupies bits 8k+7..8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads defaults |
| cmd_valid | input | 1 | Load pointer from cmd_data |
| cmd_data | input | 8 | Command byte |
| wr_en | input | 1 | Byte write at pointer |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Byte read at pointer |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | rd_data valid |
| pin_in | input | 16 | Pin levels from pads |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output value |
| irq_status_in | input | 16 | Status from interrupt detector |
| irq_mask | output | 16 | Mask bits, 1 = masked |
| latch_en | output | 16 | Input latch enables |
| pull_en | output | 16 | Pull resistor enables |
| pull_sel | output | 16 | Pull direction, 1 = up |
| drive_str | output | 32 | Drive strength, 2 bits per pin |

## Verification
Reads walk the defaults over every register class. This separates a wrong reset value from a wrong decode, and it catches a pointer that does not toggle, which would return the same byte twice. The input ports are read with an asymmetric pin pattern, first without and then with a mixed polarity mask, so that a swapped port, a missing XOR or a stale sample each show a different byte. The output drive is tried in three states: mixed direction in push-pull, port 0 in open-drain, and both ports in open-drain. Comparing `pin_oe`/`pin_out` across these states tells a direction fault from a mode fault. Writes to read-only and unmapped codes are followed by reads of both the target and the neighbouring writable registers.

// File: rtl/gpx_regbank.sv
module gpx_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_data,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_oe,
  output logic [15:0] pin_out,
  input  logic [15:0] irq_status_in,
  output logic [15:0] irq_mask,
  output logic [15:0] latch_en,
  output logic [15:0] pull_en,
  output logic [15:0] pull_sel,
  output logic [31:0] drive_str
);
  logic [7:0]  ptr;
  logic [15:0] pin_q, outv, pol, cfg;
  logic [1:0]  od;
  logic [7:0]  rd_nxt;
  logic        acc;

  assign acc = !cmd_valid && (wr_en || rd_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr <= 8'h00;
    end else if (cmd_valid) begin
      ptr <= cmd_data;
    end else if (acc) begin
      ptr <= {ptr[7:1], ~ptr[0]};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      outv      <= 16'hFFFF;
      pol       <= 16'h0000;
      cfg       <= 16'hFFFF;
      drive_str <= 32'hFFFF_FFFF;
      latch_en  <= 16'h0000;
      pull_en   <= 16'h0000;
      pull_sel  <= 16'hFFFF;
      irq_mask  <= 16'hFFFF;
      od        <= 2'b00;
    end else if (!cmd_valid && wr_en) begin
      case (ptr)
        8'h02: outv[7:0]       <= wr_data;
        8'h03: outv[15:8]      <= wr_data;
        8'h04: pol[7:0]        <= wr_data;
        8'h05: pol[15:8]       <= wr_data;
        8'h06: cfg[7:0]        <= wr_data;
        8'h07: cfg[15:8]       <= wr_data;
        8'h40: drive_str[7:0]  <= wr_data;
        8'h41: drive_str[15:8] <= wr_data;
        8'h42: drive_str[23:16] <= wr_data;
        8'h43: drive_str[31:24] <= wr_data;
        8'h44: latch_en[7:0]   <= wr_data;
        8'h45: latch_en[15:8]  <= wr_data;
        8'h46: pull_en[7:0]    <= wr_data;
        8'h47: pull_en[15:8]   <= wr_data;
        8'h48: pull_sel[7:0]   <= wr_data;
        8'h49: pull_sel[15:8]  <= wr_data;
        8'h4A: irq_mask[7:0]   <= wr_data;
        8'h4B: irq_mask[15:8]  <= wr_data;
        8'h4F: od              <= wr_data[1:0];
        default: ;
      endcase
    end

  always_comb begin
    case (ptr)
      8'h00: rd_nxt = pin_q[7:0] ^ pol[7:0];
      8'h01: rd_nxt = pin_q[15:8] ^ pol[15:8];
      8'h02: rd_nxt = outv[7:0];
      8'h03: rd_nxt = outv[15:8];
      8'h04: rd_nxt = pol[7:0];
      8'h05: rd_nxt = pol[15:8];
      8'h06: rd_nxt = cfg[7:0];
      8'h07: rd_nxt = cfg[15:8];
      8'h40: rd_nxt = drive_str[7:0];
      8'h41: rd_nxt = drive_str[15:8];
      8'h42: rd_nxt = drive_str[23:16];
      8'h43: rd_nxt = drive_str[31:24];
      8'h44: rd_nxt = latch_en[7:0];
      8'h45: rd_nxt = latch_en[15:8];
      8'h46: rd_nxt = pull_en[7:0];
      8'h47: rd_nxt = pull_en[15:8];
      8'h48: rd_nxt = pull_sel[7:0];
      8'h49: rd_nxt = pull_sel[15:8];
      8'h4A: rd_nxt = irq_mask[7:0];
      8'h4B: rd_nxt = irq_mask[15:8];
      8'h4C: rd_nxt = irq_status_in[7:0] & ~irq_mask[7:0];
      8'h4D: rd_nxt = irq_status_in[15:8] & ~irq_mask[15:8];
      8'h4F: rd_nxt = {6'b0, od};
      default: rd_nxt = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en && !wr_en && !cmd_valid;
      if (rd_en && !wr_en && !cmd_valid) rd_data <= rd_nxt;
    end

  logic [15:0] od_pin;
  assign od_pin  = {{8{od[1]}}, {8{od[0]}}};
  assign pin_oe  = ~cfg & (~od_pin | ~outv);
  assign pin_out = outv & ~od_pin;
endmodule

// File: rtl/gpx_regbank_chk.sv
module gpx_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  ptr,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic [15:0] pin_oe,
  input logic [15:0] pin_out,
  input logic [15:0] cfg,
  input logic [1:0]  od,
  input logic [15:0] irq_mask
);
  logic [15:0] odm;
  logic        unmapped;
  assign odm = {{8{od[1]}}, {8{od[0]}}};
  assign unmapped = (ptr > 8'h07) && ((ptr < 8'h40) || (ptr > 8'h4F) || (ptr == 8'h4E));

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && (wr_en || rd_en)) |=> ptr == ($past(ptr) ^ 8'h01)); // R2
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !cmd_valid) |=> rd_valid); // R2
  AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & cfg) == 16'h0); // R4
  AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & odm) == 16'h0); // R5
  AST_OD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !cmd_valid && ptr == 8'h4F) |=> rd_data[7:2] == 6'h0); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !cmd_valid && unmapped) |=> rd_data == 8'h00); // R7
  AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !cmd_valid && ptr == 8'h4C) |=> (rd_data & $past(irq_mask[7:0])) == 8'h00); // R8
endmodule

bind gpx_regbank gpx_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wr_en(wr_en), .rd_en(rd_en),
  .ptr(ptr), .rd_data(rd_data), .rd_valid(rd_valid), .pin_oe(pin_oe),
  .pin_out(pin_out), .cfg(cfg), .od(od), .irq_mask(irq_mask)
);

// File: tb/sim_gpx_regbank.sv
module sim_gpx_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, wr_en = 0, rd_en = 0;
  logic [7:0] cmd_data = 0, wr_data = 0;
  logic [15:0] pin_in = 0, irq_status_in = 0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [15:0] pin_oe, pin_out, irq_mask, latch_en, pull_en, pull_sel;
  logic [31:0] drive_str;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpx_regbank u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op_cmd(logic [7:0] c);
    cmd_valid = 1; cmd_data = c; @(negedge clk); cmd_valid = 0;
  endtask
  task automatic op_wr(logic [7:0] d);
    wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0;
  endtask
  task automatic op_rd(logic [7:0] e, string tag);
    rd_en = 1; exp_q.push_back(e); tag_q.push_back(tag); @(negedge clk); rd_en = 0;
  endtask

  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_q.size() == 0) check("R2 unexpected rd_valid", 1, 0);
    else check(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
  end

  initial begin
    #(CLK_PERIOD*20000);
    check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe reset", pin_oe, 16'h0);
    check("R9 mask reset", irq_mask, 16'hFFFF);
    check("R9 drive reset", drive_str, 32'hFFFF_FFFF);
    check("R9 pull_sel reset", pull_sel, 16'hFFFF);
    check("R9 pull_en/latch reset", {pull_en, latch_en}, 32'h0);
    rst_n = 1; @(negedge clk);
    // R1 defaults, R2 pointer toggle
    op_cmd(8'h02); op_rd(8'hFF, "R1 out0"); op_rd(8'hFF, "R1 out1");
    op_cmd(8'h04); op_rd(8'h00, "R1 pol0"); op_rd(8'h00, "R1 pol1");
    op_cmd(8'h06); op_rd(8'hFF, "R1 cfg0"); op_rd(8'hFF, "R1 cfg1");
    op_cmd(8'h43); op_rd(8'hFF, "R1 drv3"); op_rd(8'hFF, "R1 drv2");
    op_cmd(8'h45); op_rd(8'h00, "R1 latch1");
    op_cmd(8'h46); op_rd(8'h00, "R1 pen0");
    op_cmd(8'h49); op_rd(8'hFF, "R1 psel1");
    op_cmd(8'h4A); op_rd(8'hFF, "R1 mask0");
    op_cmd(8'h4F); op_rd(8'h00, "R1 od"); op_rd(8'h00, "R7 unmapped 4E");
    // R3 input ports
    pin_in = 16'hA53C; @(negedge clk);
    op_cmd(8'h00); op_rd(8'h3C, "R3 in0"); op_rd(8'hA5, "R3 in1");
    op_cmd(8'h04); op_wr(8'h0F); op_wr(8'hF0);
    op_cmd(8'h00); op_rd(8'h33, "R3 in0 inv"); op_rd(8'h55, "R3 in1 inv");
    // R4 push-pull
    op_cmd(8'h02); op_wr(8'h5A); op_wr(8'hC3);
    op_cmd(8'h06); op_wr(8'h00); op_wr(8'h0F);
    check("R4 oe", pin_oe, 16'hF0FF);
    check("R4 out", pin_out & pin_oe, 16'hC35A & 16'hF0FF);
    // R5 open drain, R6 reserved bits
    op_cmd(8'h4F); op_wr(8'h01);
    check("R5 oe port0 od", pin_oe, 16'hF0A5);
    check("R5 out port0 od", pin_out[7:0], 8'h00);
    op_cmd(8'h4F); op_wr(8'hFF);
    check("R5 oe both od", pin_oe, 16'h30A5);
    check("R5 out both od", pin_out, 16'h0);
    op_cmd(8'h4F); op_rd(8'h03, "R6 reserved zero");
    // R7 ignored writes
    op_cmd(8'h00); op_wr(8'h12); op_wr(8'h34);
    op_cmd(8'h00); op_rd(8'h33, "R7 in0 unchanged"); op_rd(8'h55, "R7 in1 unchanged");
    op_cmd(8'h02); op_rd(8'h5A, "R7 out0 unchanged");
    irq_status_in = 16'h0FF0;
    op_cmd(8'h4C); op_wr(8'hAA);
    op_cmd(8'h20); op_wr(8'h77);
    op_cmd(8'h20); op_rd(8'h00, "R7 unmapped read");
    op_cmd(8'h4C); op_rd(8'h00, "R8 all masked");
    // R8 masked status
    op_cmd(8'h4A); op_wr(8'h0F); op_wr(8'hFF);
    op_cmd(8'h4C); op_rd(8'hF0, "R8 status0"); op_rd(8'h00, "R8 status1");
    check("R9 mask out", irq_mask, 16'hFF0F);
    // R9 config outputs
    op_cmd(8'h40); op_wr(8'h11); op_wr(8'h22);
    op_cmd(8'h42); op_wr(8'h33); op_wr(8'h44);
    check("R9 drive", drive_str, 32'h4433_2211);
    op_cmd(8'h44); op_wr(8'h81); op_wr(8'h18);
    check("R9 latch", latch_en, 16'h1881);
    op_cmd(8'h46); op_wr(8'h0C); op_wr(8'hC0);
    check("R9 pull_en", pull_en, 16'hC00C);
    op_cmd(8'h48); op_wr(8'h00);
    check("R9 pull_sel", pull_sel, 16'hFF00);
    // R2 write beats read
    op_cmd(8'h02); wr_en = 1; rd_en = 1; wr_data = 8'h66; @(negedge clk); wr_en = 0; rd_en = 0;
    check("R2 no rd_valid on collision", rd_valid, 0);
    op_rd(8'hC3, "R2 ptr toggled after write");
    repeat (3) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule